// File: doc/BRIEF.md
# Control Endpoint OUT Transfer Tracker

This block follows the host-to-device data stage of a USB control endpoint. It sits between the serial interface engine and the endpoint receive FIFO. For each received OUT packet it takes one event that carries the byte count, and it answers with an ACK or NAK decision. The FIFO storage stays elsewhere. This block tracks only how many bytes the FIFO holds.

A transfer is complete when a packet arrives that is shorter than the maximum packet size. A zero-length packet that comes after one or more full-size packets also completes it. When that happens the block raises a sticky end-of-transfer flag and refuses all further host data until software clears the flag. Until then, software can read the byte count of what remains in the FIFO. The block also keeps a sticky per-packet flag, and a fill-level flag that sets when the count rises past a software threshold.

Top module: `ctl_out_tracker`

## Requirements
- R1: Each accepted (ACKed) packet sets the sticky `eop_flag`. A pulse on `clr_eop` clears the flag, but a set in the same cycle wins over the clear.
- R2: An accepted packet whose length lies between 1 and MAX_PKT-1 sets the sticky `eot_flag`. A pulse on `clr_eot` clears it.
- R3: An accepted zero-length packet sets `eot_flag` only if the last accepted packet was exactly MAX_PKT bytes. Otherwise it sets `eop_flag` alone. A MAX_PKT packet never sets `eot_flag`.
- R4: While `eot_flag` is 1, every packet is NAKed. Such a packet leaves `fifo_count`, `eop_flag` and the full-size-packet memory unchanged.
- R5: `hs_valid` is 1 for exactly the one cycle after a cycle with `pkt_valid` high. In that cycle `hs_nak` is 1 for NAK and 0 for ACK.
- R6: `fifo_count` grows by the length of each accepted packet. It drops by one for each `rd_strobe` while nonzero, and a strobe at zero is ignored.
- R7: `lvl_flag` sets when `fifo_count` moves from at most `lvl_thresh` to above it. A pulse on `clr_lvl` clears it.
- R8: A packet for which `fifo_count + pkt_len` would exceed FIFO_DEPTH is NAKed. The count, the flags and the full-size-packet memory stay unchanged.
- R9: After reset all flags are 0, `fifo_count` is 0, `hs_valid` is 0, and no full-size packet is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_valid | input | 1 | One-cycle pulse: an OUT packet was received without error |
| pkt_len | input | $clog2(MAX_PKT+1) | Byte count of the packet (0..MAX_PKT) |
| rd_strobe | input | 1 | Software removed one byte from the FIFO |
| lvl_thresh | input | $clog2(FIFO_DEPTH+1) | Fill-level threshold |
| clr_eop | input | 1 | Clear strobe for eop_flag |
| clr_eot | input | 1 | Clear strobe for eot_flag |
| clr_lvl | input | 1 | Clear strobe for lvl_flag |
| hs_valid | output | 1 | Handshake decision valid |
| hs_nak | output | 1 | 1 = NAK, 0 = ACK |
| eop_flag | output | 1 | Sticky packet-received flag |
| eot_flag | output | 1 | Sticky transfer-complete flag |
| lvl_flag | output | 1 | Sticky fill-threshold flag |
| fifo_count | output | $clog2(FIFO_DEPTH+1) | Bytes held in the FIFO |

## Verification
The bench sends a zero-length packet after full-size packets, and a zero-length packet on its own. A design that ends transfers on every zero-length packet, or on none, flags the wrong one. It also sends packets while the transfer is complete and packets that would overflow the FIFO. A design that lets these through would ACK them or change the count or the full-size memory. The bench also reads at an empty FIFO, where a design without a guard wraps the count. It sets a threshold crossed by exactly one packet, so that an off-by-one comparison shows up as a wrong level flag.

// File: rtl/ctl_out_pkg.sv
package ctl_out_pkg;
   typedef enum logic {
      HS_ACK = 1'b0,
      HS_NAK = 1'b1
   } hs_e;

   // index of each sticky flag in the flag vector
   localparam int unsigned FLG_EOP = 0;
   localparam int unsigned FLG_EOT = 1;
   localparam int unsigned FLG_LVL = 2;
   localparam int unsigned FLG_NUM = 3;
endpackage

// File: rtl/ctl_out_classify.sv
module ctl_out_classify #(
   parameter int unsigned MAX_PKT    = 8,
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned LEN_W      = $clog2(MAX_PKT + 1),
   parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_valid,
   input  logic [LEN_W-1:0] pkt_len,
   input  logic             xfer_done,
   input  logic [LVL_W-1:0] level,
   output logic             accept,
   output logic             set_eop,
   output logic             set_eot
);
   localparam int unsigned SUM_W = LVL_W + 1;

   logic             after_max_q;
   logic [SUM_W-1:0] sum;
   logic             room;
   logic             is_max;
   logic             is_zero;

   always_comb begin
      sum     = SUM_W'(level) + SUM_W'(pkt_len);
      room    = (sum <= SUM_W'(FIFO_DEPTH));
      is_max  = (pkt_len == LEN_W'(MAX_PKT));
      is_zero = (pkt_len == '0);
      accept  = pkt_valid & ~xfer_done & room;
      set_eop = accept;
      set_eot = accept & ((~is_zero & ~is_max) | (is_zero & after_max_q));
   end

   // remembers whether the last accepted packet was full size
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      after_max_q <= 1'b0;
      else if (accept) after_max_q <= is_max;
   end
endmodule

// File: rtl/ctl_out_level.sv
module ctl_out_level #(
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned LEN_W      = 4,
   parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_en,
   input  logic [LEN_W-1:0] add_len,
   input  logic             rd_strobe,
   input  logic [LVL_W-1:0] thresh,
   output logic [LVL_W-1:0] level,
   output logic             lvl_rise
);
   logic [LVL_W-1:0] level_d;
   logic [LVL_W-1:0] inc;
   logic             dec;

   always_comb begin
      inc      = add_en ? LVL_W'(add_len) : '0;
      dec      = rd_strobe & (level != '0);
      level_d  = level + inc - LVL_W'(dec);
      lvl_rise = (level <= thresh) & (level_d > thresh);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level <= '0;
      else        level <= level_d;
   end
endmodule

// File: rtl/ctl_out_flag.sv
module ctl_out_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/ctl_out_tracker.sv
module ctl_out_tracker
   import ctl_out_pkg::*;
#(
   parameter int unsigned MAX_PKT    = 8,
   parameter int unsigned FIFO_DEPTH = 16,
   localparam int unsigned LEN_W     = $clog2(MAX_PKT + 1),
   localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_valid,
   input  logic [LEN_W-1:0] pkt_len,
   input  logic             rd_strobe,
   input  logic [LVL_W-1:0] lvl_thresh,
   input  logic             clr_eop,
   input  logic             clr_eot,
   input  logic             clr_lvl,
   output logic             hs_valid,
   output logic             hs_nak,
   output logic             eop_flag,
   output logic             eot_flag,
   output logic             lvl_flag,
   output logic [LVL_W-1:0] fifo_count
);
   if (MAX_PKT < 1) begin : g_chk_max
      $error("MAX_PKT must be at least 1");
   end
   if (FIFO_DEPTH < MAX_PKT) begin : g_chk_depth
      $error("FIFO_DEPTH must hold one full packet");
   end

   logic               accept;
   logic               set_eop;
   logic               set_eot;
   logic               lvl_rise;
   logic [FLG_NUM-1:0] flg_set;
   logic [FLG_NUM-1:0] flg_clr;
   logic [FLG_NUM-1:0] flg_q;
   hs_e                hs_q;

   ctl_out_classify #(
      .MAX_PKT(MAX_PKT), .FIFO_DEPTH(FIFO_DEPTH), .LEN_W(LEN_W), .LVL_W(LVL_W)
   ) u_cls (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
      .xfer_done(flg_q[FLG_EOT]), .level(fifo_count),
      .accept(accept), .set_eop(set_eop), .set_eot(set_eot)
   );

   ctl_out_level #(
      .FIFO_DEPTH(FIFO_DEPTH), .LEN_W(LEN_W), .LVL_W(LVL_W)
   ) u_lvl (
      .clk(clk), .rst_n(rst_n), .add_en(accept), .add_len(pkt_len),
      .rd_strobe(rd_strobe), .thresh(lvl_thresh),
      .level(fifo_count), .lvl_rise(lvl_rise)
   );

   always_comb begin
      flg_set          = '0;
      flg_clr          = '0;
      flg_set[FLG_EOP] = set_eop;
      flg_set[FLG_EOT] = set_eot;
      flg_set[FLG_LVL] = lvl_rise;
      flg_clr[FLG_EOP] = clr_eop;
      flg_clr[FLG_EOT] = clr_eot;
      flg_clr[FLG_LVL] = clr_lvl;
   end

   for (genvar i = 0; i < FLG_NUM; i++) begin : g_flag
      ctl_out_flag u_flag (
         .clk(clk), .rst_n(rst_n), .set(flg_set[i]), .clr(flg_clr[i]), .q(flg_q[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_valid <= 1'b0;
         hs_q     <= HS_ACK;
      end else begin
         hs_valid <= pkt_valid;
         hs_q     <= (pkt_valid & ~accept) ? HS_NAK : HS_ACK;
      end
   end

   assign hs_nak   = (hs_q == HS_NAK);
   assign eop_flag = flg_q[FLG_EOP];
   assign eot_flag = flg_q[FLG_EOT];
   assign lvl_flag = flg_q[FLG_LVL];
endmodule

// File: rtl/ctl_out_tracker_chk.sv
module ctl_out_tracker_chk #(
   parameter int unsigned MAX_PKT    = 8,
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned LEN_W      = $clog2(MAX_PKT + 1),
   parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pkt_valid,
   input logic [LEN_W-1:0] pkt_len,
   input logic             rd_strobe,
   input logic             clr_eot,
   input logic             hs_valid,
   input logic             hs_nak,
   input logic             eop_flag,
   input logic             eot_flag,
   input logic [LVL_W-1:0] fifo_count
);
   p_ack_sets_eop_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hs_valid && !hs_nak |-> eop_flag);

   p_short_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && !eot_flag && pkt_len != '0 && pkt_len < LEN_W'(MAX_PKT)
      && ({1'b0, fifo_count} + (LVL_W+1)'(pkt_len) <= (LVL_W+1)'(FIFO_DEPTH))
      |=> eot_flag);

   p_full_no_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && !eot_flag && !clr_eot && pkt_len == LEN_W'(MAX_PKT) |=> !eot_flag);

   p_nak_when_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && eot_flag |=> hs_valid && hs_nak);

   p_hs_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |=> hs_valid);

   p_hs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_valid |=> !hs_valid);

   p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eot_flag && !rd_strobe |=> $stable(fifo_count));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= LVL_W'(FIFO_DEPTH));
endmodule

bind ctl_out_tracker ctl_out_tracker_chk #(
   .MAX_PKT(MAX_PKT), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
   .rd_strobe(rd_strobe), .clr_eot(clr_eot), .hs_valid(hs_valid), .hs_nak(hs_nak),
   .eop_flag(eop_flag), .eot_flag(eot_flag), .fifo_count(fifo_count)
);

// File: tb/sim_ctl_out_tracker.sv
module sim_ctl_out_tracker;
   localparam int unsigned MAXP  = 8;
   localparam int unsigned DEPTH = 16;
   localparam int unsigned LEN_W = $clog2(MAXP + 1);
   localparam int unsigned LVL_W = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pkt_valid = 1'b0;
   logic [LEN_W-1:0] pkt_len = '0;
   logic             rd_strobe = 1'b0;
   logic [LVL_W-1:0] lvl_thresh = LVL_W'(DEPTH);
   logic             clr_eop = 1'b0, clr_eot = 1'b0, clr_lvl = 1'b0;
   logic             hs_valid, hs_nak, eop_flag, eot_flag, lvl_flag;
   logic [LVL_W-1:0] fifo_count;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ctl_out_tracker #(.MAX_PKT(MAXP), .FIFO_DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
      .rd_strobe(rd_strobe), .lvl_thresh(lvl_thresh), .clr_eop(clr_eop),
      .clr_eot(clr_eot), .clr_lvl(clr_lvl), .hs_valid(hs_valid), .hs_nak(hs_nak),
      .eop_flag(eop_flag), .eot_flag(eot_flag), .lvl_flag(lvl_flag),
      .fifo_count(fifo_count)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive in one cycle, outputs are registered: sample one negedge later
   task automatic send(int len);
      @(negedge clk);
      pkt_valid = 1'b1;
      pkt_len   = LEN_W'(len);
      @(negedge clk);
      pkt_valid = 1'b0;
   endtask

   task automatic read_bytes(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rd_strobe = 1'b1;
         @(negedge clk);
         rd_strobe = 1'b0;
      end
   endtask

   task automatic clear_all();
      @(negedge clk);
      clr_eop = 1'b1; clr_eot = 1'b1; clr_lvl = 1'b1;
      @(negedge clk);
      clr_eop = 1'b0; clr_eot = 1'b0; clr_lvl = 1'b0;
   endtask

   task automatic t_reset();
      check("R9 eop after reset", eop_flag, 0);
      check("R9 eot after reset", eot_flag, 0);
      check("R9 lvl after reset", lvl_flag, 0);
      check("R9 count after reset", fifo_count, 0);
      check("R9 hs_valid after reset", hs_valid, 0);
   endtask

   task automatic t_short_and_hold();
      send(5);
      check("R5 hs_valid", hs_valid, 1);
      check("R5 ACK short", hs_nak, 0);
      check("R1 eop set", eop_flag, 1);
      check("R2 eot on short", eot_flag, 1);
      check("R6 count after 5", fifo_count, 5);
      @(negedge clk);
      check("R5 hs_valid one cycle", hs_valid, 0);
      // clear eop, then a packet while done must not set it again
      @(negedge clk); clr_eop = 1'b1; @(negedge clk); clr_eop = 1'b0;
      send(3);
      check("R4 NAK while done", hs_nak, 1);
      check("R4 count held", fifo_count, 5);
      check("R4 eop untouched", eop_flag, 0);
      read_bytes(5);
      check("R6 drained", fifo_count, 0);
      read_bytes(1);
      check("R6 read at zero ignored", fifo_count, 0);
      clear_all();
      check("R2 eot cleared", eot_flag, 0);
   endtask

   task automatic t_full_then_zlp();
      send(8);
      check("R3 full pkt no eot", eot_flag, 0);
      check("R1 eop on full", eop_flag, 1);
      check("R6 count 8", fifo_count, 8);
      clear_all();
      send(0);
      check("R3 zlp ACK", hs_nak, 0);
      check("R3 zlp after full ends", eot_flag, 1);
      check("R3 eop on zlp", eop_flag, 1);
      check("R6 zlp count", fifo_count, 8);
      read_bytes(8);
      clear_all();
   endtask

   task automatic t_lone_zlp();
      send(3);
      clear_all();
      read_bytes(3);
      send(0);
      check("R3 lone zlp eop", eop_flag, 1);
      check("R3 lone zlp no eot", eot_flag, 0);
      // eop set and clear in same cycle: set wins
      @(negedge clk);
      pkt_valid = 1'b1; pkt_len = LEN_W'(0); clr_eop = 1'b1;
      @(negedge clk);
      pkt_valid = 1'b0; clr_eop = 1'b0;
      check("R1 set beats clear", eop_flag, 1);
      clear_all();
   endtask

   task automatic t_overflow_level();
      lvl_thresh = LVL_W'(10);
      send(8);
      check("R7 below thresh", lvl_flag, 0);
      send(8);
      check("R7 crossed thresh", lvl_flag, 1);
      check("R6 count 16", fifo_count, 16);
      check("R3 two full no eot", eot_flag, 0);
      clear_all();
      send(1);
      check("R8 overflow NAK", hs_nak, 1);
      check("R8 count held", fifo_count, 16);
      check("R8 no eot", eot_flag, 0);
      check("R8 no eop", eop_flag, 0);
      check("R7 lvl cleared", lvl_flag, 0);
      read_bytes(16);
      send(0);
      check("R8 full memory kept, zlp ends", eot_flag, 1);
      clear_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_short_and_hold();
      t_full_then_zlp();
      t_lone_zlp();
      t_overflow_level();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule